// File: doc/BRIEF.md
# Overlay Configuration Register Slave

This block is a small register slave that sits between a host's memory-mapped write channel and a chain of time-multiplexed functional units. It follows the AXI-Lite write handshakes (address, data and response channels). The host retargets the chain to a new kernel at run time, with no device reconfiguration. First it names a functional unit by writing a tag, then it writes that unit's 32-bit instruction. Last, it writes the pacing register twice: once with the number of input words, then with the initiation interval minus one.

Each instruction write fires a one-cycle load pulse that carries the current tag and the instruction word. The word count and the interval-minus-one value are held steady for the read pacing controller. All configuration outputs are fanned out unchanged to four replicated 32-bit overlay lanes. Only single-beat writes exist. Read-back is not provided.

The write channel is a four-state machine:
- `WR_IDLE` accepts both the address and the data.
- `WR_ADDR_HELD` has the address and waits for the data.
- `WR_DATA_HELD` has the data and waits for the address.
- `WR_RESP` drives the response until the host takes it.

The transitions are:
- IDLE→RESP when both handshakes happen in one cycle.
- IDLE→ADDR_HELD on the address alone.
- IDLE→DATA_HELD on the data alone.
- ADDR_HELD→RESP on the data.
- DATA_HELD→RESP on the address.
- RESP→IDLE on `s_bready`.

Top module: `overlay_cfg_regfile`

## Requirements
- R1: After reset, `s_awready` and `s_wready` are 1 and `s_bvalid` is 0. All lane outputs are 0. The stored tag is 0, and the pacing phase selects the word count.
- R2: Address and data may be accepted in the same cycle or in either order. In the cycle after the later handshake, `s_bvalid` is 1 with `s_bresp` = 2'b00 (OKAY). It stays 1 until a cycle with `s_bready` high.
- R3: While a response is pending, `s_awready` and `s_wready` are both 0.
- R4: A write to offset 0x30 stores `s_wdata[3:0]` as the tag. Higher data bits are ignored, and no load pulse is produced.
- R5: A write to offset 0x34 raises `lane_load` for exactly one cycle. That cycle is the one after `s_bvalid` first rises. In it, `lane_tag` is the stored tag and `lane_instr` is the written word.
- R6: The tag persists across instruction writes. Rewriting 0x34 delivers the new word to the same tag, and a new 0x30 write retargets later loads.
- R7: Writes to offset 0x38 alternate. The first after reset sets `lane_count`, the next sets `lane_iim1`, and so on. Each update is visible in the cycle after `s_bvalid` first rises.
- R8: A write to any other offset completes with OKAY. It changes no output and does not advance the 0x38 phase.
- R9: All four lanes carry identical configuration values at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 8 | Write byte offset |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| lane_load | output | 4 | Instruction load pulse, one bit per lane |
| lane_tag | output | 16 | Target tag, 4 bits per lane |
| lane_instr | output | 128 | Instruction word, 32 bits per lane |
| lane_count | output | 128 | Input word count, 32 bits per lane |
| lane_iim1 | output | 128 | Initiation interval minus one, 32 bits per lane |

## Verification
The response is due one cycle after the later of the two handshakes. The configuration results (load pulse, tag, word, count, interval) are due one cycle after that, because the commit pulse is registered once more in the register stage. The bench drives on falling edges. It samples the response at the first falling edge after the last handshake edge, and the configuration outputs one falling edge later. The pulse's return to 0 is checked one falling edge after that. Response stalls of several cycles confirm that the load pulse does not stretch and that neither channel reopens early.

// File: rtl/ovl_cfg_pkg.sv
package ovl_cfg_pkg;

    typedef enum logic [1:0] {
        WR_IDLE      = 2'd0,
        WR_ADDR_HELD = 2'd1,
        WR_DATA_HELD = 2'd2,
        WR_RESP      = 2'd3
    } wr_state_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_TAG   = 2'd1,
        TGT_INSTR = 2'd2,
        TGT_PACE  = 2'd3
    } cfg_target_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/ovl_wr_channel.sv
module ovl_wr_channel
    import ovl_cfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output logic              commit,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [DATA_W-1:0] cmt_data
);

    wr_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              commit_q;
    logic              aw_hs, w_hs;

    assign aw_hs = awvalid && awready;
    assign w_hs  = wvalid && wready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (awvalid && wvalid) state_d = WR_RESP;
                else if (awvalid)      state_d = WR_ADDR_HELD;
                else if (wvalid)       state_d = WR_DATA_HELD;
            end
            WR_ADDR_HELD: if (wvalid)  state_d = WR_RESP;
            WR_DATA_HELD: if (awvalid) state_d = WR_RESP;
            WR_RESP:      if (bready)  state_d = WR_IDLE;
            default:                   state_d = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        unique case (state_q)
            WR_IDLE:      begin awready = 1'b1; wready = 1'b1; end
            WR_ADDR_HELD: wready  = 1'b1;
            WR_DATA_HELD: awready = 1'b1;
            WR_RESP:      bvalid  = 1'b1;
            default:      bvalid  = 1'b0;
        endcase
    end

    assign bresp = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            data_q   <= '0;
            commit_q <= 1'b0;
        end else begin
            if (aw_hs) addr_q <= awaddr;
            if (w_hs)  data_q <= wdata;
            commit_q <= (state_d == WR_RESP) && (state_q != WR_RESP);
        end
    end

    assign commit   = commit_q;
    assign cmt_addr = addr_q;
    assign cmt_data = data_q;

    // R2: response held until taken
    assert_bvalid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    // R2: commit pulse only while the response is presented
    assert_commit_in_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> bvalid);
    // R3: no new handshake while a response is pending
    assert_no_accept_in_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bvalid) && !$past(bready) |-> !awready && !wready);

endmodule

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
    import ovl_cfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter logic [ADDR_W-1:0] OFS_TAG   = 8'h30,
    parameter logic [ADDR_W-1:0] OFS_INSTR = 8'h34,
    parameter logic [ADDR_W-1:0] OFS_PACE  = 8'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cmt_addr,
    input  logic [DATA_W-1:0] cmt_data,
    output logic              load_stb,
    output logic [TAG_W-1:0]  load_tag,
    output logic [DATA_W-1:0] load_instr,
    output logic [DATA_W-1:0] word_count,
    output logic [DATA_W-1:0] ii_m1
);

    cfg_target_e tgt;
    logic [TAG_W-1:0]  tag_q;
    logic              pace_phase_q;
    logic              stb_q;
    logic [TAG_W-1:0]  ltag_q;
    logic [DATA_W-1:0] linstr_q, count_q, iim1_q;

    always_comb begin
        if      (cmt_addr == OFS_TAG)   tgt = TGT_TAG;
        else if (cmt_addr == OFS_INSTR) tgt = TGT_INSTR;
        else if (cmt_addr == OFS_PACE)  tgt = TGT_PACE;
        else                            tgt = TGT_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q        <= '0;
            pace_phase_q <= 1'b0;
            stb_q        <= 1'b0;
            ltag_q       <= '0;
            linstr_q     <= '0;
            count_q      <= '0;
            iim1_q       <= '0;
        end else begin
            stb_q <= 1'b0;
            if (commit) begin
                unique case (tgt)
                    TGT_TAG:   tag_q <= cmt_data[TAG_W-1:0];
                    TGT_INSTR: begin
                        stb_q    <= 1'b1;
                        ltag_q   <= tag_q;
                        linstr_q <= cmt_data;
                    end
                    TGT_PACE: begin
                        if (pace_phase_q) iim1_q  <= cmt_data;
                        else              count_q <= cmt_data;
                        pace_phase_q <= ~pace_phase_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign load_stb   = stb_q;
    assign load_tag   = ltag_q;
    assign load_instr = linstr_q;
    assign word_count = count_q;
    assign ii_m1      = iim1_q;

    // R5: load pulse lasts a single cycle
    assert_load_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);
    // R5: load pulse follows a committed write
    assert_load_after_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_stb) |-> $past(commit));
    // R7: a count update leaves the phase pointing at the interval
    assert_count_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_count) |-> pace_phase_q);
    // R7: an interval update leaves the phase pointing at the count
    assert_iim1_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ii_m1) |-> !pace_phase_q);

endmodule

// File: rtl/ovl_lane_fanout.sv
module ovl_lane_fanout #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic                    load_stb,
    input  logic [TAG_W-1:0]        load_tag,
    input  logic [DATA_W-1:0]       load_instr,
    input  logic [DATA_W-1:0]       word_count,
    input  logic [DATA_W-1:0]       ii_m1,
    output logic [LANES-1:0]        lane_load,
    output logic [LANES*TAG_W-1:0]  lane_tag,
    output logic [LANES*DATA_W-1:0] lane_instr,
    output logic [LANES*DATA_W-1:0] lane_count,
    output logic [LANES*DATA_W-1:0] lane_iim1
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_load[g]                     = load_stb;
        assign lane_tag[g*TAG_W +: TAG_W]       = load_tag;
        assign lane_instr[g*DATA_W +: DATA_W]   = load_instr;
        assign lane_count[g*DATA_W +: DATA_W]   = word_count;
        assign lane_iim1[g*DATA_W +: DATA_W]    = ii_m1;
    end

endmodule

// File: rtl/overlay_cfg_regfile.sv
module overlay_cfg_regfile
    import ovl_cfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_awvalid,
    output logic                    s_awready,
    input  logic [ADDR_W-1:0]       s_awaddr,
    input  logic                    s_wvalid,
    output logic                    s_wready,
    input  logic [DATA_W-1:0]       s_wdata,
    output logic                    s_bvalid,
    input  logic                    s_bready,
    output logic [1:0]              s_bresp,
    output logic [LANES-1:0]        lane_load,
    output logic [LANES*TAG_W-1:0]  lane_tag,
    output logic [LANES*DATA_W-1:0] lane_instr,
    output logic [LANES*DATA_W-1:0] lane_count,
    output logic [LANES*DATA_W-1:0] lane_iim1
);

    logic              commit;
    logic [ADDR_W-1:0] cmt_addr;
    logic [DATA_W-1:0] cmt_data;
    logic              load_stb;
    logic [TAG_W-1:0]  load_tag;
    logic [DATA_W-1:0] load_instr, word_count, ii_m1;

    ovl_wr_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
        .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata),
        .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
        .commit(commit), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
    );

    ovl_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
        .load_stb(load_stb), .load_tag(load_tag), .load_instr(load_instr),
        .word_count(word_count), .ii_m1(ii_m1)
    );

    ovl_lane_fanout #(.LANES(LANES), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_fan (
        .load_stb(load_stb), .load_tag(load_tag), .load_instr(load_instr),
        .word_count(word_count), .ii_m1(ii_m1),
        .lane_load(lane_load), .lane_tag(lane_tag), .lane_instr(lane_instr),
        .lane_count(lane_count), .lane_iim1(lane_iim1)
    );

    // R2: the response code is OKAY whenever it is presented
    assert_bresp_okay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_bvalid) |-> s_bresp == RESP_OKAY && $past(s_awready || s_wready));

endmodule

// File: tb/sim_overlay_cfg_regfile.sv
`timescale 1ns/1ps
module sim_overlay_cfg_regfile;

    localparam int LANES = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0;
    logic [7:0]  s_awaddr = '0;
    logic [31:0] s_wdata = '0;
    logic        s_awready, s_wready, s_bvalid;
    logic [1:0]  s_bresp;
    logic [3:0]  lane_load;
    logic [15:0] lane_tag;
    logic [127:0] lane_instr, lane_count, lane_iim1;

    int n_chk = 0, n_fail = 0;
    logic        cap_load;
    logic [3:0]  cap_tag;
    logic [31:0] cap_instr;

    always #5 clk = ~clk;

    overlay_cfg_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .lane_load(lane_load), .lane_tag(lane_tag), .lane_instr(lane_instr),
        .lane_count(lane_count), .lane_iim1(lane_iim1)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R9: every lane slice must match the expected value
    function automatic logic lanes_eq32(input logic [127:0] v, input logic [31:0] e);
        for (int i = 0; i < LANES; i++) if (v[i*32 +: 32] !== e) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk_pace(input logic [31:0] ec, input logic [31:0] ei, input string req);
        chk(lanes_eq32(lane_count, ec), {req, " count"}, lane_count[31:0], ec);
        chk(lanes_eq32(lane_iim1, ei),  {req, " iim1"},  lane_iim1[31:0], ei);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // mode 0: same cycle, 1: address first, 2: data first; hold: cycles of bready low
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input int mode, input int hold);
        if (mode == 0) begin
            s_awvalid = 1; s_awaddr = a; s_wvalid = 1; s_wdata = d;
            @(posedge clk); @(negedge clk);
            s_awvalid = 0; s_wvalid = 0;
        end else begin
            if (mode == 1) begin s_awvalid = 1; s_awaddr = a; end
            else           begin s_wvalid = 1;  s_wdata = d;  end
            @(posedge clk); @(negedge clk);
            s_awvalid = 0; s_wvalid = 0;
            chk(s_bvalid == 0, "R2 no response after one handshake", s_bvalid, 0);
            if (mode == 1) begin s_wvalid = 1;  s_wdata = d;  end
            else           begin s_awvalid = 1; s_awaddr = a; end
            @(posedge clk); @(negedge clk);
            s_awvalid = 0; s_wvalid = 0;
        end
        chk(s_bvalid == 1, "R2 response due", s_bvalid, 1);
        chk(s_bresp == 2'b00, "R2 OKAY", s_bresp, 0);
        s_bready = (hold == 0);
        @(posedge clk); @(negedge clk);
        cap_load  = lane_load[0];
        cap_tag   = lane_tag[3:0];
        cap_instr = lane_instr[31:0];
        chk(lane_load == {LANES{lane_load[0]}}, "R9 load lanes", lane_load, {LANES{lane_load[0]}});
        chk(lanes_eq32(lane_instr, cap_instr) &&
            lane_tag == {LANES{cap_tag}}, "R9 tag/instr lanes", lane_tag, {LANES{cap_tag}});
        for (int i = 0; i < hold; i++) begin
            chk(s_bvalid == 1, "R2 response held", s_bvalid, 1);
            chk(!s_awready && !s_wready, "R3 channels closed", {s_awready, s_wready}, 0);
            if (i == hold - 1) s_bready = 1;
            @(posedge clk); @(negedge clk);
            chk(lane_load == 0, "R5 single-cycle load", lane_load, 0);
        end
        chk(s_bvalid == 0, "R2 response taken", s_bvalid, 0);
        s_bready = 0;
        @(posedge clk); @(negedge clk);
        chk(lane_load == 0, "R5 load drops", lane_load, 0);
    endtask

    task automatic t_reset();
        chk(s_awready && s_wready, "R1 ready after reset", {s_awready, s_wready}, 3);
        chk(s_bvalid == 0, "R1 no response", s_bvalid, 0);
        chk(lane_load == 0 && lane_tag == 0 && lane_instr == 0, "R1 load outputs", lane_load, 0);
        chk_pace(0, 0, "R1");
    endtask

    task automatic t_tag_instr();
        wr(8'h30, 32'h0000_0005, 0, 0);
        chk(cap_load == 0, "R4 tag write gives no load", cap_load, 0);
        wr(8'h34, 32'h3033_D080, 1, 2);
        chk(cap_load == 1, "R5 load pulse", cap_load, 1);
        chk(cap_tag == 4'h5, "R5 load tag", cap_tag, 5);
        chk(cap_instr == 32'h3033_D080, "R5 load word", cap_instr, 32'h3033_D080);
        wr(8'h34, 32'h0885_2000, 2, 0);
        chk(cap_load == 1 && cap_tag == 4'h5, "R6 tag persists", cap_tag, 5);
        chk(cap_instr == 32'h0885_2000, "R6 rewritten word", cap_instr, 32'h0885_2000);
        wr(8'h30, 32'hFFFF_FFF9, 2, 1);
        wr(8'h34, 32'hDEAD_BEEF, 0, 3);
        chk(cap_load == 1 && cap_tag == 4'h9, "R4 R6 retag, upper bits ignored", cap_tag, 9);
        chk(cap_instr == 32'hDEAD_BEEF, "R6 retag word", cap_instr, 32'hDEAD_BEEF);
    endtask

    task automatic t_pace();
        wr(8'h38, 32'd20, 0, 0);
        chk_pace(20, 0, "R7 first write");
        wr(8'h38, 32'd3, 1, 1);
        chk_pace(20, 3, "R7 second write");
        wr(8'h38, 32'd40, 2, 0);
        chk_pace(40, 3, "R7 third write");
    endtask

    task automatic t_unmapped();
        wr(8'h3C, 32'h1234_5678, 0, 0);
        chk(cap_load == 0, "R8 no load", cap_load, 0);
        chk_pace(40, 3, "R8 3C ignored");
        wr(8'h00, 32'h0000_0034, 1, 0);
        chk_pace(40, 3, "R8 00 ignored");
        wr(8'h34, 32'h0000_00AA, 0, 0);
        chk(cap_tag == 4'h9, "R8 tag untouched", cap_tag, 9);
        wr(8'h38, 32'd7, 0, 0);
        chk_pace(40, 7, "R8 phase not advanced");
    endtask

    task automatic t_reset_again();
        do_reset();
        t_reset();
        wr(8'h34, 32'h0000_0011, 0, 0);
        chk(cap_load == 1 && cap_tag == 4'h0, "R1 tag reset", cap_tag, 0);
        wr(8'h38, 32'd9, 0, 0);
        chk_pace(9, 0, "R1 phase reset");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_tag_instr();
        t_pace();
        t_unmapped();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule